// File: doc/BRIEF.md
# Integer Add/Subtract Execute Unit with Selectable Flag Update

This block is the integer execute stage of a load/store processor core. It works on three operands: two sources and a destination index. It performs addition and subtraction. The second source is either a register value or a signed 13-bit immediate that the block sign-extends to 32 bits. The sources are only read. The result leaves the block with a write enable and the destination index, so that the register file outside the block can store it.

A set of four condition flags is held in a register inside the unit. The flags are negative, zero, signed overflow and carry/borrow. Only the flag-setting variants of add and subtract write them; every other operation leaves them untouched. The block also decodes the common aliases:
- Compare is a flag-setting subtract whose result is thrown away.
- Increment adds one to the first source.
- Move passes the second operand through.
- Clear produces zero.

Destination index 0 names the hard-wired zero register, so the block never raises the write enable for it.

Top module: `alu_exec_unit`

## Requirements
- R1: Operation code 0 (add) gives `res = src_a + operand2` modulo 2^32. The result appears one clock after the edge that samples `op_valid`, with `wr_en` high and `wr_idx` equal to `dst_idx`.
- R2: When `use_imm` is 1, operand2 is `imm` (13-bit two's complement, range -4096..4095) sign-extended to 32 bits. When `use_imm` is 0, operand2 is `src_b`.
- R3: Operation code 1 (subtract) gives `res = src_a - operand2` modulo 2^32.
- R4: Operation code 2 (flag-setting add) gives the add result and loads the flags. The flag bits are `flags[3]`=N (result bit 31), `flags[2]`=Z (result is zero), `flags[1]`=V (signed overflow) and `flags[0]`=C (unsigned carry out of bit 31).
- R5: Operation code 3 (flag-setting subtract) gives the subtract result and loads N and Z as in R4. C is set when `src_a < operand2` unsigned (a borrow). V is set when the operands differ in sign and the result sign differs from `src_a`.
- R6: Operation codes 0, 1, 4, 5 and 7 leave `flags` unchanged.
- R7: A destination index of 0 never raises `wr_en`, whatever the operation.
- R8: Operation code 6 (compare) updates the flags exactly as R5 does and never raises `wr_en`.
- R9: Operation code 7 (increment) gives `res = src_a + 1`. It ignores `src_b`, `use_imm` and `imm`.
- R10: Operation code 4 (move) gives `res = operand2`. Operation code 5 (clear) gives `res = 0`.
- R11: While `rst_n` is low, `flags`, `wr_en` and `res` are all zero.
- R12: A cycle with `op_valid` low drops `wr_en` on the next clock and leaves `flags` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation code (see requirements) |
| src_a | input | 32 | First source value |
| src_b | input | 32 | Second source value |
| use_imm | input | 1 | Select immediate as second operand |
| imm | input | 13 | Signed immediate field |
| dst_idx | input | 5 | Destination register index |
| res | output | 32 | Registered result |
| wr_en | output | 1 | Registered destination write enable |
| wr_idx | output | 5 | Registered destination index |
| flags | output | 4 | Condition flags {N,Z,V,C} |

## Verification
All three results are due one clock after the edge that samples the operation: `res`, `wr_en`/`wr_idx` and `flags` each pass through a single register. The bench drives each operation half a cycle before that sampling edge. It then compares every output half a cycle after the edge against its behavioural model, so each comparison sits exactly one register stage after its stimulus. Flag holds and suppressed writes are checked in that same slot. Back-to-back operations therefore show any flag update that lands in the wrong cycle.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_ADDF = 3'd2,
    OP_SUBF = 3'd3,
    OP_MOV  = 3'd4,
    OP_CLR  = 3'd5,
    OP_CMP  = 3'd6,
    OP_INC  = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    K_ADD  = 2'd0,
    K_SUB  = 2'd1,
    K_PASS = 2'd2,
    K_ZERO = 2'd3
  } alu_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/alu_decode.sv
`timescale 1ns/1ps
module alu_decode
  import alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 13,
  parameter int IDX_W = 5
) (
  input  logic [2:0]       op,
  input  logic [W-1:0]     src_b,
  input  logic             use_imm,
  input  logic [IMM_W-1:0] imm,
  input  logic [IDX_W-1:0] dst,
  output logic [W-1:0]     opnd_b,
  output alu_kind_e        kind,
  output logic             set_flags,
  output logic             do_write
);
  localparam int EXT_W = W - IMM_W;

  alu_op_e          op_e;
  logic [W-1:0]     imm_ext;
  logic [W-1:0]     one_w;

  assign op_e    = alu_op_e'(op);
  assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign one_w   = W'(1);

  always_comb begin
    opnd_b    = use_imm ? imm_ext : src_b;
    kind      = K_ADD;
    set_flags = 1'b0;
    case (op_e)
      OP_ADD:  kind = K_ADD;
      OP_SUB:  kind = K_SUB;
      OP_ADDF: begin kind = K_ADD; set_flags = 1'b1; end
      OP_SUBF: begin kind = K_SUB; set_flags = 1'b1; end
      OP_MOV:  kind = K_PASS;
      OP_CLR:  kind = K_ZERO;
      OP_CMP:  begin kind = K_SUB; set_flags = 1'b1; end
      OP_INC:  begin kind = K_ADD; opnd_b = one_w; end
      default: kind = K_ADD;
    endcase
    do_write = (op_e != OP_CMP) && (dst != '0);
  end

  // R2: immediate path must carry the sign bit into all upper bits
  always_comb begin
    if (use_imm && op_e != OP_INC)
      assert_imm_sign_R2: assert (opnd_b[W-1:IMM_W-1] == {(EXT_W+1){imm[IMM_W-1]}});
  end
endmodule

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cflag,
  output logic         vflag
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  assign b_eff = sub ? ~b : b;
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
  assign sum   = wide[W-1:0];
  // for subtract, carry out of a + ~b + 1 is the inverse of borrow
  assign cflag = sub ? ~wide[W] : wide[W];
  assign vflag = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);

  // R5: borrow must agree with an unsigned magnitude comparison
  always_comb begin
    if (sub)
      assert_borrow_R5: assert (cflag == (a < b));
  end
endmodule

// File: rtl/alu_flag_reg.sv
`timescale 1ns/1ps
module alu_flag_reg
  import alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  alu_flags_t fin,
  output alu_flags_t fq
);
  alu_flags_t fnext;

  always_comb begin
    fnext = fq;
    if (upd) fnext = fin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fq <= '0;
    else        fq <= fnext;
  end

  // R4: a zero result can never also be negative
  assert_z_excludes_n_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fq.z |-> !fq.n);
endmodule

// File: rtl/alu_exec_unit.sv
`timescale 1ns/1ps
module alu_exec_unit
  import alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 13,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [W-1:0]     src_a,
  input  logic [W-1:0]     src_b,
  input  logic             use_imm,
  input  logic [IMM_W-1:0] imm,
  input  logic [IDX_W-1:0] dst_idx,
  output logic [W-1:0]     res,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [3:0]       flags
);
  logic [W-1:0]     opnd_b;
  alu_kind_e        kind;
  logic             set_flags;
  logic             do_write;
  logic [W-1:0]     sum;
  logic             cf, vf;
  logic [W-1:0]     res_d;
  alu_flags_t       fin, fq;
  logic [W-1:0]     res_q;
  logic             we_q;
  logic [IDX_W-1:0] idx_q;
  logic [W-1:0]     res_n;
  logic             we_n;
  logic [IDX_W-1:0] idx_n;

  alu_decode #(.W(W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_dec (
    .op(op_code), .src_b(src_b), .use_imm(use_imm), .imm(imm), .dst(dst_idx),
    .opnd_b(opnd_b), .kind(kind), .set_flags(set_flags), .do_write(do_write)
  );

  alu_addsub #(.W(W)) u_as (
    .a(src_a), .b(opnd_b), .sub(kind == K_SUB),
    .sum(sum), .cflag(cf), .vflag(vf)
  );

  always_comb begin
    case (kind)
      K_PASS:  res_d = opnd_b;
      K_ZERO:  res_d = '0;
      default: res_d = sum;
    endcase
    fin.n = sum[W-1];
    fin.z = (sum == '0);
    fin.v = vf;
    fin.c = cf;
  end

  alu_flag_reg u_flg (
    .clk(clk), .rst_n(rst_n), .upd(op_valid && set_flags), .fin(fin), .fq(fq)
  );

  // next-state for result registers
  always_comb begin
    res_n = res_q;
    idx_n = idx_q;
    we_n  = 1'b0;
    if (op_valid) begin
      res_n = res_d;
      idx_n = dst_idx;
      we_n  = do_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      we_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      res_q <= res_n;
      we_q  <= we_n;
      idx_q <= idx_n;
    end
  end

  assign res    = res_q;
  assign wr_en  = we_q;
  assign wr_idx = idx_q;
  assign flags  = fq;

  // R7: the zero register is never a write target
  assert_idx0_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx != '0));

  // R12: an idle cycle produces no write
  assert_idle_no_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !wr_en);

  // R6: flags move only after a flag-setting operation
  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && (op_code == 3'd2 || op_code == 3'd3 || op_code == 3'd6))
      |=> $stable(flags));

  // R8: compare never writes
  assert_cmp_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd6) |=> !wr_en);
endmodule

// File: tb/tb_alu_exec_unit.sv
`timescale 1ns/1ps
module tb_alu_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [31:0] src_a, src_b;
  logic        use_imm;
  logic [12:0] imm;
  logic [4:0]  dst_idx;
  logic [31:0] res;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [3:0]  flags;

  int total = 0;
  int bad   = 0;
  logic [3:0] mflags;

  always #2.5 clk = ~clk;

  alu_exec_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .use_imm(use_imm), .imm(imm),
    .dst_idx(dst_idx), .res(res), .wr_en(wr_en), .wr_idx(wr_idx), .flags(flags)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op, input logic ui, input logic [4:0] d, input logic v);
    if (!v) return "R12";
    if (d == 5'd0 && op != 3'd6) return "R7";
    case (op)
      3'd0: return ui ? "R2" : "R1";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd6: return "R8";
      3'd7: return "R9";
      default: return "R10";
    endcase
  endfunction

  // Behavioural reference: one operation per cycle, compared one clock later
  task automatic do_op(input logic v, input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic ui, input logic [12:0] im,
                       input logic [4:0] d);
    logic [31:0] b2, r;
    logic [32:0] w;
    logic        e_we, fl, cc, vv;
    string       t;
    op_valid = v; op_code = op; src_a = a; src_b = b; use_imm = ui; imm = im; dst_idx = d;
    t  = tag_of(op, ui, d, v);
    b2 = ui ? {{19{im[12]}}, im} : b;
    if (op == 3'd7) b2 = 32'd1;
    fl = 1'b0; cc = 1'b0; vv = 1'b0; r = 32'd0;
    if (op == 3'd1 || op == 3'd3 || op == 3'd6) begin
      w  = {1'b0, a} - {1'b0, b2};
      r  = w[31:0];
      cc = (a < b2);
      vv = (a[31] != b2[31]) && (r[31] != a[31]);
      fl = (op != 3'd1);
    end else if (op == 3'd4) begin
      r = b2;
    end else if (op == 3'd5) begin
      r = 32'd0;
    end else begin
      w  = {1'b0, a} + {1'b0, b2};
      r  = w[31:0];
      cc = w[32];
      vv = (a[31] == b2[31]) && (r[31] != a[31]);
      fl = (op == 3'd2);
    end
    e_we = v && (op != 3'd6) && (d != 5'd0);
    if (v && fl) mflags = {r[31], (r == 32'd0), vv, cc};
    @(negedge clk);
    chk({t, " wr_en"}, {31'd0, wr_en}, {31'd0, e_we});
    if (e_we) begin
      chk({t, " res"}, res, r);
      chk({t, " wr_idx"}, {27'd0, wr_idx}, {27'd0, d});
    end
    chk({t, " flags"}, {28'd0, flags}, {28'd0, mflags});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mflags = 4'd0;
    rst_n = 1'b0; op_valid = 1'b0; op_code = 3'd0; src_a = 32'd0; src_b = 32'd0;
    use_imm = 1'b0; imm = 13'd0; dst_idx = 5'd0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 flags", {28'd0, flags}, 32'd0);
    chk("R11 wr_en", {31'd0, wr_en}, 32'd0);
    chk("R11 res", res, 32'd0);
    rst_n = 1'b1;
    // R1 plain add
    do_op(1, 3'd0, 32'd5, 32'd7, 0, 13'd0, 5'd3);
    do_op(1, 3'd0, 32'hFFFF_FFFF, 32'd2, 0, 13'd0, 5'd31);
    // R2 immediate extremes
    do_op(1, 3'd0, 32'd10, 32'hDEAD, 1, 13'h1000, 5'd4);
    do_op(1, 3'd0, 32'd10, 32'hDEAD, 1, 13'h0FFF, 5'd4);
    // R3 subtract
    do_op(1, 3'd1, 32'd20, 32'd30, 0, 13'd0, 5'd5);
    // R4 flag-setting add: signed overflow, then zero with carry
    do_op(1, 3'd2, 32'h7FFF_FFFF, 32'd1, 0, 13'd0, 5'd6);
    do_op(1, 3'd2, 32'hFFFF_FFFF, 32'd0, 1, 13'd1, 5'd6);
    // R5 flag-setting subtract: borrow, then overflow
    do_op(1, 3'd3, 32'd3, 32'd5, 0, 13'd0, 5'd7);
    do_op(1, 3'd3, 32'h8000_0000, 32'd1, 0, 13'd0, 5'd7);
    // R6 plain add that overflows must not touch flags
    do_op(1, 3'd0, 32'hFFFF_FFFF, 32'd1, 0, 13'd0, 5'd8);
    // R7 destination zero
    do_op(1, 3'd0, 32'd1, 32'd1, 0, 13'd0, 5'd0);
    // R8 compare equal and less
    do_op(1, 3'd6, 32'd9, 32'd9, 0, 13'd0, 5'd7);
    do_op(1, 3'd6, 32'd9, 32'd0, 1, 13'd11, 5'd0);
    // R9 increment ignores second operand
    do_op(1, 3'd7, 32'd41, 32'd999, 1, 13'd77, 5'd9);
    do_op(1, 3'd7, 32'hFFFF_FFFF, 32'd5, 0, 13'd0, 5'd9);
    // R10 move and clear
    do_op(1, 3'd4, 32'd3, 32'd0, 1, 13'h1FFF, 5'd10);
    do_op(1, 3'd4, 32'd3, 32'h1234_5678, 0, 13'd0, 5'd10);
    do_op(1, 3'd5, 32'd3, 32'd4, 0, 13'd0, 5'd11);
    // R12 idle cycle carrying a flag-setting code
    do_op(0, 3'd3, 32'd0, 32'd1, 0, 13'd0, 5'd12);
    // mixed back-to-back traffic
    for (int i = 0; i < 400; i++) begin
      do_op(($urandom % 8) != 0, 3'($urandom % 8), $urandom, $urandom,
            1'($urandom % 2), 13'($urandom), 5'($urandom % 32));
    end
    // R11 reset mid-stream clears flags and write enable
    do_op(1, 3'd3, 32'd1, 32'd2, 0, 13'd0, 5'd1);
    rst_n = 1'b0;
    #1;
    chk("R11 flags async", {28'd0, flags}, 32'd0);
    chk("R11 wr_en async", {31'd0, wr_en}, 32'd0);
    mflags = 4'd0;
    @(negedge clk);
    rst_n = 1'b1;
    do_op(1, 3'd0, 32'd2, 32'd2, 0, 13'd0, 5'd2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule